// File: doc/BRIEF.md
# Compare-Driven External Interrupt Edge Logic

This block raises interrupt requests for a group of compare/capture channels. Each channel's interrupt input is taken from one of two sources. While the channel's compare mode is off, the source is the external pin level. While compare mode is on, the source is the channel's internal compare-match signal, which is low whenever there is no match. The selected source is sampled once per clock. A request flag is raised when the sample shows the chosen edge, and the flag stays set until software clears it.

The low-numbered channels, `NUM_POL` of them, each have a polarity bit. This bit chooses whether the request is raised on the active (rising) edge or on the inactive (falling) edge. All other channels request only on the rising edge.

Switching the source while the pin is high gives a real 1-to-0 step at the edge detector. On a channel set to falling polarity, this step raises a request. The block keeps this behaviour, and software can discard the request with a clear before it enables the interrupt.

Each channel also has a port latch paired with a shadow latch. While compare mode owns the output, port writes are held in the shadow and do not disturb the pin. When compare mode is released, the held value is transferred to the port latch.

Top module: `cmpirq_edge_top`

## Requirements
- R1: With `cmp_on[i]`=0 the edge detector of channel i watches `pin_lvl[i]`; with `cmp_on[i]`=1 it watches `cmp_hit[i]`, and pin activity is then ignored.
- R2: For a channel i below `NUM_POL`, `fall_sel[i]`=0 selects a 0-to-1 transition of the source and `fall_sel[i]`=1 selects a 1-to-0 transition.
- R3: Channels at index `NUM_POL` and above raise a request only on a 0-to-1 transition of their source; a 1-to-0 transition never sets their flag.
- R4: The source is sampled at every rising clock edge. When the source differs from the previous sample in the selected direction, `irq_flag[i]` reads 1 after that same clock edge.
- R5: A set flag stays 1 until a cycle in which `irq_clr[i]`=1 with no new edge; after that edge the flag reads 0.
- R6: If `irq_clr[i]`=1 in the same cycle as a selected edge, the flag is 1 afterwards.
- R7: With falling polarity and the pin high, setting `cmp_on` while `cmp_hit` is 0 sets the flag at the next clock edge. A following clear removes the flag, and it does not come back while the compare signal stays low.
- R8: The first sample after reset release only loads the history and never raises a request, even when a source is already high.
- R9: While reset is active, all flags, port latches and shadow latches are 0.
- R10: With `cmp_on[i]`=0, a cycle with `latch_wr[i]`=1 loads `latch_din[i]` into the port latch, and `port_out[i]` shows it after the clock edge.
- R11: While `cmp_on[i]`=1, `port_out[i]` equals `cmp_hit[i]`; a port write in that time reaches only the shadow latch.
- R12: In the cycle where `cmp_on[i]` falls, the port latch loads the shadow value, so `port_out[i]` then shows the last value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_lvl | input | NUM_CH | External pin level per channel |
| cmp_hit | input | NUM_CH | Internal compare-match signal per channel (1 = match) |
| cmp_on | input | NUM_CH | Compare-mode enable per channel |
| fall_sel | input | NUM_POL | Polarity per programmable channel (1 = falling edge) |
| irq_clr | input | NUM_CH | Software clear strobe per request flag |
| latch_wr | input | NUM_CH | Port-latch write strobe per channel |
| latch_din | input | NUM_CH | Port-latch write data per channel |
| irq_flag | output | NUM_CH | Interrupt request flags |
| port_out | output | NUM_CH | Port output level per channel |

## Verification
Two functions can land in the same cycle. The first pair is the software clear and a newly detected edge on the same flag. The bench brings the source to the opposite level beforehand, then drives the clear strobe together with the level change, and it expects the flag to read 1 after that edge. The second pair is the compare-mode release and a pending shadow value. The bench writes a value while compare mode owns the output, drops `cmp_on`, and expects `port_out` to show the shadowed value rather than the value held earlier. A behavioural reference model checks every cycle, and directed checks mark each corner case.

// File: rtl/cmpirq_pkg.sv
package cmpirq_pkg;

  // Pick the interrupt source: pin level or compare-match signal.
  function automatic logic src_pick(input logic cmp_mode, input logic pin, input logic hit);
    return cmp_mode ? hit : pin;
  endfunction

  // Edge hit for the selected direction.
  function automatic logic edge_hit(input logic cur, input logic prev, input logic fall);
    return fall ? (prev & ~cur) : (cur & ~prev);
  endfunction

  // Flag update: a new edge takes priority over a clear.
  function automatic logic flag_next(input logic hit, input logic cur_flag, input logic clr);
    return hit | (cur_flag & ~clr);
  endfunction

endpackage

// File: rtl/cmpirq_channel.sv
module cmpirq_channel
  import cmpirq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic pin_lvl,
  input  logic cmp_hit,
  input  logic cmp_on,
  input  logic fall_sel,
  input  logic clr_req,
  output logic src_o,
  output logic edge_o,
  output logic flag_o
);

  logic src_q;
  logic flag_q;

  assign src_o  = src_pick(cmp_on, pin_lvl, cmp_hit);
  assign edge_o = armed & edge_hit(src_o, src_q, fall_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      src_q  <= src_o;
      flag_q <= flag_next(edge_o, flag_q, clr_req);
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/cmpirq_port_shadow.sv
module cmpirq_port_shadow #(
  parameter int NUM_CH = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] cmp_on,
  input  logic [NUM_CH-1:0] cmp_hit,
  input  logic [NUM_CH-1:0] wr_stb,
  input  logic [NUM_CH-1:0] wr_val,
  output logic [NUM_CH-1:0] port_o,
  output logic [NUM_CH-1:0] shadow_o
);

  logic [NUM_CH-1:0] latch_q;
  logic [NUM_CH-1:0] shadow_q;
  logic [NUM_CH-1:0] cmp_on_q;
  logic [NUM_CH-1:0] release_ev;

  assign release_ev = cmp_on_q & ~cmp_on;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        latch_q[g]  <= 1'b0;
        shadow_q[g] <= 1'b0;
        cmp_on_q[g] <= 1'b0;
      end else begin
        cmp_on_q[g] <= cmp_on[g];
        if (wr_stb[g]) begin
          shadow_q[g] <= wr_val[g];
        end
        if (wr_stb[g] && !cmp_on[g]) begin
          latch_q[g] <= wr_val[g];
        end else if (release_ev[g]) begin
          latch_q[g] <= shadow_q[g];
        end
      end
    end

    assign port_o[g] = cmp_on[g] ? cmp_hit[g] : latch_q[g];
  end

  assign shadow_o = shadow_q;

endmodule

// File: rtl/cmpirq_edge_top.sv
module cmpirq_edge_top #(
  parameter int NUM_CH  = 5,
  parameter int NUM_POL = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CH-1:0]  pin_lvl,
  input  logic [NUM_CH-1:0]  cmp_hit,
  input  logic [NUM_CH-1:0]  cmp_on,
  input  logic [NUM_POL-1:0] fall_sel,
  input  logic [NUM_CH-1:0]  irq_clr,
  input  logic [NUM_CH-1:0]  latch_wr,
  input  logic [NUM_CH-1:0]  latch_din,
  output logic [NUM_CH-1:0]  irq_flag,
  output logic [NUM_CH-1:0]  port_out
);

  localparam int FIXED_CH = NUM_CH - NUM_POL;

  logic              armed_q;
  logic [NUM_CH-1:0] fall_v;
  logic [NUM_CH-1:0] src_sel;
  logic [NUM_CH-1:0] edge_ev;
  logic [NUM_CH-1:0] shadow_q;

  always_ff @(posedge clk) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    if (g < NUM_POL) begin : g_pol
      assign fall_v[g] = fall_sel[g];
    end else begin : g_fixed
      assign fall_v[g] = 1'b0;
    end

    cmpirq_channel u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .armed   (armed_q),
      .pin_lvl (pin_lvl[g]),
      .cmp_hit (cmp_hit[g]),
      .cmp_on  (cmp_on[g]),
      .fall_sel(fall_v[g]),
      .clr_req (irq_clr[g]),
      .src_o   (src_sel[g]),
      .edge_o  (edge_ev[g]),
      .flag_o  (irq_flag[g])
    );
  end

  cmpirq_port_shadow #(.NUM_CH(NUM_CH)) u_port (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmp_on  (cmp_on),
    .cmp_hit (cmp_hit),
    .wr_stb  (latch_wr),
    .wr_val  (latch_din),
    .port_o  (port_out),
    .shadow_o(shadow_q)
  );

  if (FIXED_CH < 0) begin : g_bad_cfg
    initial $error("NUM_POL exceeds NUM_CH");
  end

endmodule

// File: rtl/cmpirq_edge_chk.sv
module cmpirq_edge_chk #(
  parameter int NUM_CH  = 5,
  parameter int NUM_POL = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] cmp_on,
  input logic [NUM_CH-1:0] cmp_hit,
  input logic [NUM_CH-1:0] irq_clr,
  input logic [NUM_CH-1:0] src_sel,
  input logic [NUM_CH-1:0] edge_ev,
  input logic [NUM_CH-1:0] irq_flag,
  input logic [NUM_CH-1:0] port_out
);

  localparam logic [NUM_CH-1:0] POL_MASK   = NUM_CH'((1 << NUM_POL) - 1);
  localparam logic [NUM_CH-1:0] FIXED_MASK = ~POL_MASK;

  // R4
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_flag & ~$past(irq_flag) & ~$past(edge_ev)) == '0));

  // R6
  edge_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(edge_ev) & ~irq_flag) == '0));

  // R5
  flag_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(irq_flag) & ~irq_flag & ~$past(irq_clr)) == '0));

  // R3
  fixed_rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_ev & ~src_sel & FIXED_MASK) == '0));

  // R11
  port_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmp_on & $past(cmp_on) & ~(cmp_hit ^ $past(cmp_hit)) & (port_out ^ $past(port_out))) == '0));

endmodule

bind cmpirq_edge_top cmpirq_edge_chk #(.NUM_CH(NUM_CH), .NUM_POL(NUM_POL)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cmp_on  (cmp_on),
  .cmp_hit (cmp_hit),
  .irq_clr (irq_clr),
  .src_sel (src_sel),
  .edge_ev (edge_ev),
  .irq_flag(irq_flag),
  .port_out(port_out)
);

// File: tb/test_cmpirq_edge_top.sv
module test_cmpirq_edge_top;

  localparam int NCH  = 5;
  localparam int NPOL = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NCH-1:0]  pin_lvl, cmp_hit, cmp_on, irq_clr, latch_wr, latch_din;
  logic [NPOL-1:0] fall_sel;
  logic [NCH-1:0]  irq_flag, port_out;

  int n_checks = 0;
  int n_fails  = 0;
  string cur_req = "R9";

  // reference model state
  int m_prev[NCH];
  int m_flag[NCH];
  int m_latch[NCH];
  int m_shadow[NCH];
  int m_cen_prev[NCH];
  int m_armed;

  always #5 clk = ~clk;

  cmpirq_edge_top #(.NUM_CH(NCH), .NUM_POL(NPOL)) i_cmpirq_edge_top (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .cmp_hit(cmp_hit),
    .cmp_on(cmp_on), .fall_sel(fall_sel), .irq_clr(irq_clr),
    .latch_wr(latch_wr), .latch_din(latch_din),
    .irq_flag(irq_flag), .port_out(port_out)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_armed = 0;
      for (int i = 0; i < NCH; i++) begin
        m_prev[i] = 0; m_flag[i] = 0; m_latch[i] = 0; m_shadow[i] = 0; m_cen_prev[i] = 0;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        int src, fall, hit;
        src  = cmp_on[i] ? int'(cmp_hit[i]) : int'(pin_lvl[i]);
        fall = (i < NPOL) ? int'(fall_sel[i]) : 0;
        hit  = 0;
        if (m_armed != 0) begin
          if (fall != 0) hit = (m_prev[i] == 1 && src == 0) ? 1 : 0;
          else           hit = (m_prev[i] == 0 && src == 1) ? 1 : 0;
        end
        if (hit != 0)        m_flag[i] = 1;
        else if (irq_clr[i]) m_flag[i] = 0;
        m_prev[i] = src;
        if (latch_wr[i] && !cmp_on[i])           m_latch[i] = int'(latch_din[i]);
        else if (m_cen_prev[i] == 1 && !cmp_on[i]) m_latch[i] = m_shadow[i];
        if (latch_wr[i]) m_shadow[i] = int'(latch_din[i]);
        m_cen_prev[i] = int'(cmp_on[i]);
      end
      m_armed = 1;
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
    for (int i = 0; i < NCH; i++) begin
      logic ep;
      ep = cmp_on[i] ? cmp_hit[i] : logic'(m_latch[i] != 0);
      chk(cur_req, $sformatf("model flag[%0d]", i), irq_flag[i], logic'(m_flag[i] != 0));
      chk(cur_req, $sformatf("model port[%0d]", i), port_out[i], ep);
    end
  endtask

  initial begin
    #1_000_000;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pin_lvl = '0; cmp_hit = '0; cmp_on = '0; irq_clr = '0;
    latch_wr = '0; latch_din = '0; fall_sel = '0;
    pin_lvl[0] = 1'b1; pin_lvl[2] = 1'b1;
    repeat (3) step();
    cur_req = "R9";
    chk("R9", "flags in reset", |irq_flag, 1'b0);
    chk("R9", "ports in reset", |port_out, 1'b0);

    // R8: sources high at release, no request
    cur_req = "R8";
    rst_n = 1'b1;
    step(); step();
    chk("R8", "flag0 after release", irq_flag[0], 1'b0);
    chk("R8", "flag2 after release", irq_flag[2], 1'b0);

    // R2/R4: channel 0 rising
    cur_req = "R2";
    pin_lvl[0] = 1'b0; step();
    chk("R2", "flag0 on fall with rising pol", irq_flag[0], 1'b0);
    pin_lvl[0] = 1'b1; step();
    chk("R4", "flag0 after rising edge", irq_flag[0], 1'b1);

    // R5: hold then clear
    cur_req = "R5";
    step(); step();
    chk("R5", "flag0 held", irq_flag[0], 1'b1);
    irq_clr[0] = 1'b1; step(); irq_clr[0] = 1'b0;
    chk("R5", "flag0 cleared", irq_flag[0], 1'b0);

    // R2: falling polarity on channel 0
    cur_req = "R2";
    fall_sel[0] = 1'b1; pin_lvl[0] = 1'b0; step();
    chk("R2", "flag0 on falling pol fall", irq_flag[0], 1'b1);
    irq_clr[0] = 1'b1; step(); irq_clr[0] = 1'b0;
    pin_lvl[0] = 1'b1; step();
    chk("R2", "flag0 no set on rise with falling pol", irq_flag[0], 1'b0);
    fall_sel[0] = 1'b0;

    // R3: fixed channel 2
    cur_req = "R3";
    pin_lvl[2] = 1'b0; step();
    chk("R3", "flag2 on fall", irq_flag[2], 1'b0);
    pin_lvl[2] = 1'b1; step();
    chk("R3", "flag2 on rise", irq_flag[2], 1'b1);
    irq_clr[2] = 1'b1; step(); irq_clr[2] = 1'b0;

    // R6: clear and edge in same cycle on channel 0 (rising pol, pin high)
    cur_req = "R6";
    pin_lvl[0] = 1'b0; step();
    pin_lvl[0] = 1'b1; step();
    chk("R6", "flag0 set before collision", irq_flag[0], 1'b1);
    pin_lvl[0] = 1'b0; step();
    pin_lvl[0] = 1'b1; irq_clr[0] = 1'b1; step(); irq_clr[0] = 1'b0;
    chk("R6", "edge wins over clear", irq_flag[0], 1'b1);
    irq_clr[0] = 1'b1; step(); irq_clr[0] = 1'b0;
    chk("R6", "plain clear afterwards", irq_flag[0], 1'b0);

    // R7: spurious falling edge on compare enable, channel 1
    cur_req = "R7";
    fall_sel[1] = 1'b1; pin_lvl[1] = 1'b1; step(); step();
    chk("R7", "flag1 quiet with pin high", irq_flag[1], 1'b0);
    cmp_hit[1] = 1'b0; cmp_on[1] = 1'b1; step();
    chk("R7", "spurious flag1 on compare enable", irq_flag[1], 1'b1);
    irq_clr[1] = 1'b1; step(); irq_clr[1] = 1'b0;
    chk("R7", "flag1 discarded", irq_flag[1], 1'b0);
    step(); step();
    chk("R7", "flag1 stays clear", irq_flag[1], 1'b0);

    // R1: compare source on channel 3, pin ignored
    cur_req = "R1";
    cmp_on[3] = 1'b1; step();
    pin_lvl[3] = 1'b1; step();
    chk("R1", "pin ignored in compare mode", irq_flag[3], 1'b0);
    cmp_hit[3] = 1'b1; step();
    chk("R1", "compare match sets flag3", irq_flag[3], 1'b1);
    irq_clr[3] = 1'b1; step(); irq_clr[3] = 1'b0;
    cmp_on[3] = 1'b0; pin_lvl[3] = 1'b0; step();
    chk("R1", "source back to pin (falling)", irq_flag[3], 1'b0);
    pin_lvl[3] = 1'b1; step();
    chk("R1", "pin rise sets flag3", irq_flag[3], 1'b1);

    // R10/R11/R12: port latch and shadow on channel 4
    cur_req = "R10";
    latch_wr[4] = 1'b1; latch_din[4] = 1'b1; step(); latch_wr[4] = 1'b0;
    chk("R10", "port4 after write", port_out[4], 1'b1);
    cur_req = "R11";
    cmp_hit[4] = 1'b0; cmp_on[4] = 1'b1; step();
    chk("R11", "port4 follows compare low", port_out[4], 1'b0);
    latch_wr[4] = 1'b1; latch_din[4] = 1'b0; step(); latch_wr[4] = 1'b0;
    chk("R11", "write during compare invisible", port_out[4], 1'b0);
    cmp_hit[4] = 1'b1; step();
    chk("R11", "port4 follows compare high", port_out[4], 1'b1);
    cur_req = "R12";
    cmp_on[4] = 1'b0; cmp_hit[4] = 1'b0; step();
    chk("R12", "shadow moved to latch on release", port_out[4], 1'b0);
    step();
    chk("R12", "port4 holds shadow value", port_out[4], 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule